// File: doc/BRIEF.md
# Converter Calibration Cycle Sequencer

This block controls one calibration pass of a delta-sigma converter. A serial front end delivers a complete command byte with a one-cycle valid strobe. When that byte asks for a calibration, the sequencer decides between an offset pass and a gain pass, and between a self pass and a system pass. It captures the word-rate, filter-rate and span settings that are in force at that moment. It then runs a down-counter for the exact number of clock cycles the pass needs.

The length of a pass is the single-conversion length minus a fixed shortfall. The single-conversion length is looked up from a parameter table indexed by the word-rate code. A filter-rate select of 1 stretches it by one fifth. The shortfall depends on the pass type and the filter-rate select.

At the end of the pass the value on the stand-in filter input is stored in the offset register or the gain register. The serial data line then drops low and stays low until the serial port is touched again. Touching the port while the pass is running aborts it and leaves both registers untouched.

Top module: `cal_seq`

## Requirements
- R1: A command is accepted only while no pass is running and no abort is in progress. Acceptance needs `cmd_valid` high, `cmd_byte[7]` = 1, `cmd_byte[6:3]` = 0, and `cmd_byte[2:0]` equal to one of four codes: 3'b001 self offset, 3'b010 self gain, 3'b101 system offset, 3'b110 system gain. Any other byte is ignored: `busy` stays low and both registers keep their values.
- R2: After acceptance, `busy` is high for exactly L cycles. L = T + (frs ? T/5 : 0) − S, where T is the table entry for the word-rate code (default 1200 + 160·rate). S is 608 (frs 0) or 729 (frs 1) for offset passes, and 128 (frs 0) or 153 (frs 1) for gain passes.
- R3: In the cycle after the last busy cycle, `sdo` is low. It stays low until `port_touch` or `cmd_valid` is seen, and it is high again one cycle later unless a new pass was accepted. `busy` and low `sdo` never occur together.
- R4: On completion, offset codes (3'b001, 3'b101) load `off_reg` and gain codes (3'b010, 3'b110) load `gain_reg` with `filt_result`. The other register keeps its value.
- R5: A later pass of the same type overwrites the stored value completely.
- R6: One accepted command runs exactly one pass: without a new command, `busy` does not rise again.
- R7: `port_touch` or `cmd_valid` during a running pass ends it. In the next cycle `busy` is low and `sdo` is high, and neither register changes.
- R8: `cal_rate`, `cal_frs`, `cal_bipolar` and `cal_system` hold the settings captured at acceptance. The pass length uses these captured values, and configuration changes during the pass have no effect.
- R9: After reset, `sdo` is high, `busy` is low, both registers are zero, and the latched settings are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a full command byte is present |
| cmd_byte | input | 8 | Command byte |
| port_touch | input | 1 | Serial port activity (first bit of a word) |
| cfg_word_rate | input | 4 | Word-rate code from configuration |
| cfg_frs | input | 1 | Filter-rate select from configuration |
| cfg_bipolar | input | 1 | Span setting: 1 bipolar, 0 unipolar |
| filt_result | input | DW | Calibration result from the filter stand-in |
| busy | output | 1 | High while a pass is running |
| sdo | output | 1 | Serial data line; low means a pass has completed |
| off_reg | output | DW | Stored offset calibration value |
| gain_reg | output | DW | Stored gain calibration value |
| cal_rate | output | 4 | Word-rate code captured for the pass |
| cal_frs | output | 1 | Filter-rate select captured for the pass |
| cal_bipolar | output | 1 | Span setting captured for the pass |
| cal_system | output | 1 | 1 for a system pass, 0 for a self pass |

## Verification
A wrong counter load or a wrong shortfall selection shows up as a `busy` pulse that is longer or shorter than L. It is visible at the falling edge of `busy`, up to a few thousand cycles after the command. A wrong state transition appears within one cycle of the stimulus. Examples are an `sdo` line that rises without a port touch, a pass that survives a touch, or a register that changes on abort. A wrong register select or an unlatched configuration is exposed on the first completion that follows: the wrong register holds the result, or `cal_rate` moves mid-pass.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2,
    ST_ABORT = 2'd3
  } cal_state_e;

  localparam logic [2:0] CC_SELF_OFF = 3'b001;
  localparam logic [2:0] CC_SELF_GN  = 3'b010;
  localparam logic [2:0] CC_SYS_OFF  = 3'b101;
  localparam logic [2:0] CC_SYS_GN   = 3'b110;

  function automatic logic code_known(input logic [2:0] c);
    return (c == CC_SELF_OFF) || (c == CC_SELF_GN) ||
           (c == CC_SYS_OFF)  || (c == CC_SYS_GN);
  endfunction
endpackage

// File: rtl/cal_cmd_decode.sv
`timescale 1ns/1ps
module cal_cmd_decode (
  input  logic [7:0] cmd_byte,
  output logic       start_ok,
  output logic       is_gain,
  output logic       is_system
);
  import cal_pkg::*;
  logic [2:0] code;

  always_comb begin
    code      = cmd_byte[2:0];
    start_ok  = cmd_byte[7] && (cmd_byte[6:3] == 4'd0) && code_known(code);
    is_gain   = code[1];
    is_system = code[2];
  end
endmodule

// File: rtl/cal_len_calc.sv
`timescale 1ns/1ps
module cal_len_calc #(
  parameter int unsigned CW = 16,
  parameter int unsigned NRATE = 16,
  parameter int unsigned CONV_LEN [NRATE] = '{1200, 1360, 1520, 1680, 1840, 2000, 2160, 2320,
                                              2480, 2640, 2800, 2960, 3120, 3280, 3440, 3600},
  parameter int unsigned OFF_SHORT_F0  = 608,
  parameter int unsigned OFF_SHORT_F1  = 729,
  parameter int unsigned GAIN_SHORT_F0 = 128,
  parameter int unsigned GAIN_SHORT_F1 = 153,
  localparam int unsigned RW = $clog2(NRATE)
) (
  input  logic [RW-1:0] rate,
  input  logic          frs,
  input  logic          is_gain,
  output logic [CW-1:0] len
);
  logic [CW-1:0] tbl [NRATE];

  for (genvar g = 0; g < NRATE; g++) begin : g_tbl
    assign tbl[g] = CW'(CONV_LEN[g]);
  end

  logic [CW-1:0] base, ext, shortv;

  always_comb begin
    base = tbl[rate];
    ext  = frs ? (base + (base / CW'(5))) : base;
    unique case ({is_gain, frs})
      2'b00:   shortv = CW'(OFF_SHORT_F0);
      2'b01:   shortv = CW'(OFF_SHORT_F1);
      2'b10:   shortv = CW'(GAIN_SHORT_F0);
      default: shortv = CW'(GAIN_SHORT_F1);
    endcase
    len = ext - shortv;
  end
endmodule

// File: rtl/cal_timer.sv
`timescale 1ns/1ps
module cal_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  input  logic          run_en,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (run_en && (cnt_q != '0));
    cnt_d  = load ? (load_len - CW'(1)) : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/cal_fsm.sv
`timescale 1ns/1ps
module cal_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic start_ok,
  input  logic port_touch,
  input  logic timer_zero,
  output logic accept,
  output logic run_en,
  output logic write_en,
  output logic busy,
  output logic sdo
);
  import cal_pkg::*;
  cal_state_e st_q, st_d;
  logic       touched;

  always_comb begin
    touched  = port_touch || cmd_valid;
    accept   = cmd_valid && start_ok && ((st_q == ST_IDLE) || (st_q == ST_DONE));
    run_en   = (st_q == ST_RUN);
    write_en = run_en && timer_zero && !touched;
    st_d     = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = ST_RUN;
      ST_RUN: begin
        if (touched)         st_d = ST_ABORT;
        else if (timer_zero) st_d = ST_DONE;
      end
      ST_DONE: begin
        if (accept)       st_d = ST_RUN;
        else if (touched) st_d = ST_IDLE;
      end
      default:            st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q == ST_RUN);
  assign sdo  = (st_q != ST_DONE);
endmodule

// File: rtl/cal_regs.sv
`timescale 1ns/1ps
module cal_regs #(
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          is_gain,
  input  logic          write_en,
  input  logic [DW-1:0] result,
  output logic [DW-1:0] off_reg,
  output logic [DW-1:0] gain_reg
);
  logic sel_gain_q;
  logic off_en, gain_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_gain_q <= 1'b0;
    else if (load) sel_gain_q <= is_gain;
  end

  always_comb begin
    off_en  = write_en && !sel_gain_q;
    gain_en = write_en &&  sel_gain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_reg <= '0;
    else if (off_en) off_reg <= result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_reg <= '0;
    else if (gain_en) gain_reg <= result;
  end
endmodule

// File: rtl/cal_seq.sv
`timescale 1ns/1ps
module cal_seq #(
  parameter int unsigned DW = 24,
  parameter int unsigned CW = 16,
  parameter int unsigned CONV_LEN [16] = '{1200, 1360, 1520, 1680, 1840, 2000, 2160, 2320,
                                           2480, 2640, 2800, 2960, 3120, 3280, 3440, 3600}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic          port_touch,
  input  logic [3:0]    cfg_word_rate,
  input  logic          cfg_frs,
  input  logic          cfg_bipolar,
  input  logic [DW-1:0] filt_result,
  output logic          busy,
  output logic          sdo,
  output logic [DW-1:0] off_reg,
  output logic [DW-1:0] gain_reg,
  output logic [3:0]    cal_rate,
  output logic          cal_frs,
  output logic          cal_bipolar,
  output logic          cal_system
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic          start_ok, is_gain, is_system;
  logic          accept, run_en, write_en, timer_zero;
  logic [CW-1:0] len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  cal_cmd_decode u_dec (
    .cmd_byte (cmd_byte),
    .start_ok (start_ok),
    .is_gain  (is_gain),
    .is_system(is_system)
  );

  cal_len_calc #(.CW(CW), .NRATE(16), .CONV_LEN(CONV_LEN)) u_len (
    .rate   (cfg_word_rate),
    .frs    (cfg_frs),
    .is_gain(is_gain),
    .len    (len)
  );

  cal_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cmd_valid (cmd_valid),
    .start_ok  (start_ok),
    .port_touch(port_touch),
    .timer_zero(timer_zero),
    .accept    (accept),
    .run_en    (run_en),
    .write_en  (write_en),
    .busy      (busy),
    .sdo       (sdo)
  );

  cal_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (accept),
    .load_len(len),
    .run_en  (run_en),
    .zero    (timer_zero)
  );

  cal_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (accept),
    .is_gain (is_gain),
    .write_en(write_en),
    .result  (filt_result),
    .off_reg (off_reg),
    .gain_reg(gain_reg)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cal_rate    <= 4'd0;
      cal_frs     <= 1'b0;
      cal_bipolar <= 1'b0;
      cal_system  <= 1'b0;
    end else if (accept) begin
      cal_rate    <= cfg_word_rate;
      cal_frs     <= cfg_frs;
      cal_bipolar <= cfg_bipolar;
      cal_system  <= is_system;
    end
  end
endmodule

// File: rtl/cal_seq_chk.sv
`timescale 1ns/1ps
module cal_seq_chk #(
  parameter int unsigned DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [7:0]    cmd_byte,
  input logic          port_touch,
  input logic          busy,
  input logic          sdo,
  input logic [DW-1:0] off_reg,
  input logic [DW-1:0] gain_reg,
  input logic [3:0]    cal_rate
);
  logic good_cmd;
  assign good_cmd = cmd_byte[7] && (cmd_byte[6:3] == 4'd0) &&
                    ((cmd_byte[2:0] == 3'b001) || (cmd_byte[2:0] == 3'b010) ||
                     (cmd_byte[2:0] == 3'b101) || (cmd_byte[2:0] == 3'b110));

  a_r1_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sdo && cmd_valid && !good_cmd) |=> !busy);

  a_r3_no_busy_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && !sdo));

  a_r3_fall_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo) |-> $past(busy));

  a_r3_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo && !port_touch && !cmd_valid) |=> !sdo);

  a_r4_off_write_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (off_reg != $past(off_reg)) |-> (!sdo && $past(busy)));

  a_r4_gain_write_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_reg != $past(gain_reg)) |-> (!sdo && $past(busy)));

  a_r7_touch_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (port_touch || cmd_valid)) |=> (!busy && sdo));

  a_r8_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cal_rate));
endmodule

bind cal_seq cal_seq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_byte  (cmd_byte),
  .port_touch(port_touch),
  .busy      (busy),
  .sdo       (sdo),
  .off_reg   (off_reg),
  .gain_reg  (gain_reg),
  .cal_rate  (cal_rate)
);

// File: tb/cal_seq_tb.sv
`timescale 1ns/1ps
module cal_seq_tb;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, port_touch, cfg_frs, cfg_bipolar;
  logic [7:0]    cmd_byte;
  logic [3:0]    cfg_word_rate;
  logic [DW-1:0] filt_result;
  logic          busy, sdo, cal_frs, cal_bipolar, cal_system;
  logic [DW-1:0] off_reg, gain_reg;
  logic [3:0]    cal_rate;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  cal_seq #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .port_touch(port_touch), .cfg_word_rate(cfg_word_rate), .cfg_frs(cfg_frs),
    .cfg_bipolar(cfg_bipolar), .filt_result(filt_result), .busy(busy), .sdo(sdo),
    .off_reg(off_reg), .gain_reg(gain_reg), .cal_rate(cal_rate), .cal_frs(cal_frs),
    .cal_bipolar(cal_bipolar), .cal_system(cal_system)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int rate, input bit frs, input bit gain);
    int t, s;
    t = 1200 + 160 * rate;
    if (frs) t = t + t / 5;
    if (gain) s = frs ? 153 : 128;
    else      s = frs ? 729 : 608;
    return t - s;
  endfunction

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_byte  = b;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic touch();
    @(negedge clk);
    port_touch = 1'b1;
    @(negedge clk);
    port_touch = 1'b0;
  endtask

  // Runs one pass; optionally disturbs the configuration after it starts.
  task automatic run_cal(input logic [2:0] code, input int rate, input bit frs,
                         input bit bip, input logic [DW-1:0] data, input bit disturb,
                         input string tag);
    int n;
    bit gain;
    logic [DW-1:0] off_before, gain_before;
    gain = code[1];
    off_before  = off_reg;
    gain_before = gain_reg;
    cfg_word_rate = 4'(rate);
    cfg_frs       = frs;
    cfg_bipolar   = bip;
    filt_result   = data;
    send_cmd({1'b1, 4'b0000, code});
    if (disturb) begin
      cfg_word_rate = 4'd15;
      cfg_frs       = ~frs;
      cfg_bipolar   = ~bip;
    end
    n = 0;
    while (busy && n < 20000) begin
      n++;
      @(negedge clk);
    end
    chk("R2", {tag, " busy length"}, n, exp_len(rate, frs, gain));
    chk("R3", {tag, " sdo low at end"}, sdo, 0);
    if (gain) begin
      chk("R4", {tag, " gain_reg"}, gain_reg, data);
      chk("R4", {tag, " off_reg kept"}, off_reg, off_before);
    end else begin
      chk("R4", {tag, " off_reg"}, off_reg, data);
      chk("R4", {tag, " gain_reg kept"}, gain_reg, gain_before);
    end
    chk("R8", {tag, " cal_rate"}, cal_rate, rate);
    chk("R8", {tag, " cal_frs"}, cal_frs, frs);
    chk("R8", {tag, " cal_bipolar"}, cal_bipolar, bip);
    chk("R8", {tag, " cal_system"}, cal_system, code[2]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; port_touch = 1'b0; cmd_byte = 8'h00;
    cfg_word_rate = 4'd0; cfg_frs = 1'b0; cfg_bipolar = 1'b0; filt_result = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "sdo", sdo, 1);
    chk("R9", "busy", busy, 0);
    chk("R9", "off_reg", off_reg, 0);
    chk("R9", "gain_reg", gain_reg, 0);
    chk("R9", "cal_rate", cal_rate, 0);
  endtask

  task automatic t_hold_and_release();
    repeat (6) @(negedge clk);
    chk("R3", "sdo held low", sdo, 0);
    chk("R6", "no second pass", busy, 0);
    touch();
    chk("R3", "sdo high after touch", sdo, 1);
    chk("R6", "idle after touch", busy, 0);
  endtask

  task automatic t_abort();
    logic [DW-1:0] g0;
    g0 = gain_reg;
    cfg_word_rate = 4'd4; cfg_frs = 1'b0; filt_result = 24'h0BAD00;
    send_cmd({1'b1, 4'b0000, 3'b010});
    chk("R7", "running before touch", busy, 1);
    repeat (100) @(negedge clk);
    touch();
    chk("R7", "busy after abort", busy, 0);
    chk("R7", "sdo after abort", sdo, 1);
    repeat (2000) @(negedge clk);
    chk("R7", "gain_reg unchanged", gain_reg, g0);
    chk("R7", "sdo stays high", sdo, 1);
    chk("R7", "no restart", busy, 0);
  endtask

  task automatic t_bad_cmd(input logic [7:0] b, input string what);
    logic [DW-1:0] o0, g0;
    o0 = off_reg; g0 = gain_reg;
    filt_result = 24'h777777;
    send_cmd(b);
    chk("R1", {what, " busy next"}, busy, 0);
    repeat (1500) @(negedge clk);
    chk("R1", {what, " busy later"}, busy, 0);
    chk("R1", {what, " sdo"}, sdo, 1);
    chk("R1", {what, " off_reg"}, off_reg, o0);
    chk("R1", {what, " gain_reg"}, gain_reg, g0);
  endtask

  initial begin
    t_reset();
    run_cal(3'b001, 0, 1'b0, 1'b0, 24'h123456, 1'b0, "self offset r0");
    t_hold_and_release();
    run_cal(3'b010, 3, 1'b0, 1'b1, 24'hABCDEF, 1'b0, "self gain r3");
    // R1: command accepted directly from the completed state
    run_cal(3'b101, 5, 1'b1, 1'b0, 24'h00F00D, 1'b0, "R5 system offset r5");
    chk("R5", "offset replaced", off_reg, 24'h00F00D);
    touch();
    run_cal(3'b110, 15, 1'b1, 1'b1, 24'h5A5A5A, 1'b0, "system gain r15");
    touch();
    run_cal(3'b001, 2, 1'b0, 1'b1, 24'h314159, 1'b1, "R8 cfg disturbed");
    touch();
    t_abort();
    t_bad_cmd(8'b1000_0011, "code 011");
    t_bad_cmd(8'b1000_0000, "code 000");
    t_bad_cmd(8'b0000_0001, "msb clear");
    t_bad_cmd(8'b1001_0001, "reserved set");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule